// File: doc/BRIEF.md
# Postponed DRAM Refresh Scheduler

This block sits inside a DRAM controller, next to the command arbiter. A periodic tick marks each refresh interval and adds one refresh to a backlog instead of forcing it onto the bus at once. While work is pending, the block watches the empty flags of the read and write command buffers. When both flags have stayed set for a programmable number of consecutive cycles, it asks the arbiter for refresh slots. It keeps asking, one refresh after another, for as long as the buffers stay empty.

If traffic never pauses and the backlog reaches its programmed limit, a single refresh is marked urgent so that the arbiter places it ahead of normal traffic. Opportunistic waiting then resumes. While self-refresh is enabled, the backlog is held until the controller reports that self-refresh has been entered, and it is then drained. Every accepted refresh occupies a fixed busy interval before the next one may be requested.

Top module: `refresh_postpone_sched`

## Requirements
- R1: After a synchronous active-low reset, ref_req_o and urgent_o are 0 and pend_cnt_o is 0.
- R2: Each cycle with tick_i high and no accepted refresh raises pend_cnt_o by one, up to the effective limit and no further. The effective limit is cfg_max_i, with 0 read as 1 and any value above MAX_PEND read as MAX_PEND.
- R3: An accepted refresh (ack_i high while ref_req_o is high) lowers pend_cnt_o by one. If tick_i is high in that same cycle, pend_cnt_o is unchanged.
- R4: With self-refresh disabled and a nonzero backlog, let the read and write buffers become empty together. ref_req_o then rises after exactly cfg_idle_i+1 clock edges, for cfg_idle_i from 0 to 15. A cycle in which either buffer is non-empty restarts that window.
- R5: After each refresh, the block requests the next one without a new idle window, as long as both buffers stayed empty and the backlog is nonzero. It stops once either buffer is non-empty.
- R6: With self-refresh disabled, a backlog equal to the effective limit raises ref_req_o with urgent_o high, whatever the state of the buffers. Exactly one such refresh is issued, and the block then waits again for an idle window.
- R7: Once raised, ref_req_o stays high until ack_i is seen. It is low in the cycle after acceptance, and urgent_o is never high without ref_req_o.
- R8: After an accepted refresh, ref_req_o stays low for BUSY_CYCLES+1 cycles.
- R9: While sref_en_i is high and sref_act_i is low, no refresh is requested, neither idle nor urgent. Once sref_act_i is high, the whole backlog is issued back-to-back with urgent_o low, regardless of the buffer flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse: one more refresh is due |
| rd_empty_i | input | 1 | Read command buffer is empty |
| wr_empty_i | input | 1 | Write command buffer is empty |
| sref_en_i | input | 1 | Self-refresh mode is enabled |
| sref_act_i | input | 1 | Controller has entered self-refresh |
| ack_i | input | 1 | Arbiter accepts the refresh request this cycle |
| cfg_max_i | input | PEND_W | Backlog limit (0 read as 1, clamped to MAX_PEND) |
| cfg_idle_i | input | IDLE_W | Consecutive idle cycles required |
| ref_req_o | output | 1 | Refresh command request |
| urgent_o | output | 1 | Current request preempts normal traffic |
| pend_cnt_o | output | PEND_W | Number of postponed refreshes |

## Verification
The bench builds the block with MAX_PEND of 8, IDLE_W of 4 and BUSY_CYCLES of 3. The full backlog of eight, the saturation and clamping of out-of-range limit codes (0, 12, 15), and idle thresholds of 0, 5 and 15 are therefore all reachable in short runs. The short busy interval lets the exact gap between batched refreshes be counted edge by edge. The same settings let an urgent escalation at a small limit of 3 be followed by a return to opportunistic issue.

// File: rtl/rps_pkg.sv
// Shared types and helpers for the postponed refresh scheduler.
// Assumes the limit field is wide enough to hold MAX_PEND.
package rps_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_REQ  = 2'd1,
        ST_BUSY = 2'd2
    } rps_state_e;

    // Map a programmed limit to the range 1..max_pend.
    function automatic logic [7:0] clamp_limit(input logic [7:0] cfg, input logic [7:0] max_pend);
        if (cfg == 8'd0)
            return 8'd1;
        else if (cfg > max_pend)
            return max_pend;
        else
            return cfg;
    endfunction

endpackage

// File: rtl/rps_pend_ctr.sv
// Backlog counter: counts ticks up, counts accepted refreshes down, and
// saturates at the effective limit. A tick in an accept cycle leaves it unchanged.
// Assumes dec_i is only asserted while the backlog is nonzero.
module rps_pend_ctr #(
    parameter int MAX_PEND = 8,
    parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic [PEND_W-1:0] limit_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              at_limit_o
);
    logic [PEND_W-1:0] pend_q;

    // Update the backlog on tick or accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   if (pend_q < limit_i) pend_q <= pend_q + PEND_W'(1);
                2'b01:   if (pend_q != '0)     pend_q <= pend_q - PEND_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend_o     = pend_q;
    assign at_limit_o = (pend_q != '0) && (pend_q >= limit_i);

    p_pend_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= PEND_W'(MAX_PEND));
    p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
    p_tick_accept_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && inc_i) |=> $stable(pend_q));
endmodule

// File: rtl/rps_idle_mon.sv
// Idle window monitor: counts consecutive cycles with both command buffers
// empty, saturating at its all-ones value. It restarts on any non-empty cycle
// and when an urgent refresh is accepted. Assumes threshold fits IDLE_W bits.
module rps_idle_mon #(
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_empty_i,
    input  logic              wr_empty_i,
    input  logic              clr_i,
    input  logic [IDLE_W-1:0] thr_i,
    output logic              idle_ok_o
);
    localparam logic [IDLE_W-1:0] CNT_TOP = '1;

    logic              both_empty;
    logic [IDLE_W-1:0] cnt_q;

    assign both_empty = rd_empty_i && wr_empty_i;

    // Count consecutive idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !both_empty || clr_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_TOP)
            cnt_q <= cnt_q + IDLE_W'(1);
    end

    assign idle_ok_o = both_empty && (cnt_q >= thr_i);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !both_empty |=> (cnt_q == '0));
endmodule

// File: rtl/rps_issue_fsm.sv
// Issue sequencer: decides when to request a refresh (idle window, backlog
// limit or self-refresh), holds the request until accepted, then waits a
// fixed busy interval. Assumes BUSY_CYCLES >= 1.
module rps_issue_fsm #(
    parameter int BUSY_CYCLES = 4,
    parameter int BUSY_W      = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic have_pend_i,
    input  logic at_limit_i,
    input  logic idle_ok_i,
    input  logic sref_en_i,
    input  logic sref_act_i,
    input  logic ack_i,
    output logic req_o,
    output logic urgent_o,
    output logic accept_o
);
    import rps_pkg::*;

    localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(BUSY_CYCLES - 1);

    rps_state_e        state_q;
    logic [BUSY_W-1:0] busy_q;
    logic              urg_q;
    logic              go;
    logic              go_urgent;

    // Decide whether a refresh may be requested now.
    always_comb begin
        go_urgent = 1'b0;
        if (!have_pend_i)
            go = 1'b0;
        else if (sref_en_i)
            go = sref_act_i;
        else begin
            go        = idle_ok_i || at_limit_i;
            go_urgent = at_limit_i;
        end
    end

    assign accept_o = (state_q == ST_REQ) && ack_i;

    // Sequence wait, request and busy phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            busy_q  <= '0;
            urg_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT: if (go) begin
                    state_q <= ST_REQ;
                    urg_q   <= go_urgent;
                end
                ST_REQ: if (ack_i) begin
                    state_q <= ST_BUSY;
                    busy_q  <= BUSY_LOAD;
                    urg_q   <= 1'b0;
                end
                ST_BUSY: begin
                    if (busy_q == '0) state_q <= ST_WAIT;
                    else              busy_q  <= busy_q - BUSY_W'(1);
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    assign req_o    = (state_q == ST_REQ);
    assign urgent_o = urg_q;

    p_urgent_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> req_o);
    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);
    p_drop_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);
    p_sref_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(!sref_en_i || sref_act_i));
endmodule

// File: rtl/refresh_postpone_sched.sv
// Postponed refresh scheduler top: wires the backlog counter, idle window
// monitor and issue sequencer. Assumes cfg fields are static while a request
// is outstanding and tick_i is a single-cycle pulse.
module refresh_postpone_sched #(
    parameter int MAX_PEND    = 8,
    parameter int IDLE_W      = 4,
    parameter int BUSY_CYCLES = 4,
    parameter int PEND_W      = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rd_empty_i,
    input  logic              wr_empty_i,
    input  logic              sref_en_i,
    input  logic              sref_act_i,
    input  logic              ack_i,
    input  logic [PEND_W-1:0] cfg_max_i,
    input  logic [IDLE_W-1:0] cfg_idle_i,
    output logic              ref_req_o,
    output logic              urgent_o,
    output logic [PEND_W-1:0] pend_cnt_o
);
    import rps_pkg::*;

    logic [PEND_W-1:0] limit;
    logic              at_limit;
    logic              idle_ok;
    logic              accept;
    logic              urgent_int;

    assign limit = PEND_W'(clamp_limit(8'(cfg_max_i), 8'(MAX_PEND)));

    rps_pend_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc_i(tick_i), .dec_i(accept),
        .limit_i(limit), .pend_o(pend_cnt_o), .at_limit_o(at_limit)
    );

    rps_idle_mon #(.IDLE_W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .rd_empty_i(rd_empty_i), .wr_empty_i(wr_empty_i),
        .clr_i(accept && urgent_int), .thr_i(cfg_idle_i), .idle_ok_o(idle_ok)
    );

    rps_issue_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .have_pend_i(pend_cnt_o != '0),
        .at_limit_i(at_limit), .idle_ok_i(idle_ok), .sref_en_i(sref_en_i),
        .sref_act_i(sref_act_i), .ack_i(ack_i), .req_o(ref_req_o),
        .urgent_o(urgent_int), .accept_o(accept)
    );

    assign urgent_o = urgent_int;

    p_req_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (pend_cnt_o != '0));
endmodule

// File: tb/sim_refresh_postpone_sched.sv
`timescale 1ns/1ps
module sim_refresh_postpone_sched;
    localparam int MAXP = 8;
    localparam int BUSY = 3;
    localparam int PW   = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rd_e = 1'b0, wr_e = 1'b0;
    logic sen = 1'b0, sact = 1'b0, ack = 1'b0;
    logic [PW-1:0] cmax = 4'd8;
    logic [3:0] cidle = 4'd0;
    logic req, urg;
    logic [PW-1:0] pend;
    int total = 0, bad = 0;
    logic last_urg;
    logic got;

    always #2.5 clk = ~clk;

    refresh_postpone_sched #(.MAX_PEND(MAXP), .IDLE_W(4), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rd_empty_i(rd_e), .wr_empty_i(wr_e),
        .sref_en_i(sen), .sref_act_i(sact), .ack_i(ack), .cfg_max_i(cmax),
        .cfg_idle_i(cidle), .ref_req_o(req), .urgent_o(urg), .pend_cnt_o(pend)
    );

    // entries: {cfg_max, ticks, expected backlog}
    localparam logic [11:0] TAB [8] = '{
        {4'd3, 4'd2, 4'd2}, {4'd3, 4'd5, 4'd3}, {4'd8, 4'd10, 4'd8}, {4'd0, 4'd2, 4'd1},
        {4'd12, 4'd3, 4'd3}, {4'd15, 4'd12, 4'd8}, {4'd1, 4'd1, 4'd1}, {4'd5, 4'd5, 4'd5}};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 0; ack = 0; sen = 0; sact = 0; rd_e = 0; wr_e = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
    endtask

    // Wait for a request, accept it; returns at the negedge after acceptance.
    task automatic do_ack();
        got = 1'b0;
        for (int i = 0; i < 100 && !got; i++) begin
            if (req) got = 1'b1; else @(negedge clk);
        end
        last_urg = urg;
        if (got) begin
            ack = 1'b1; @(negedge clk); ack = 1'b0;
        end
    endtask

    task automatic window(input int thr);
        do_reset();
        cmax = 4'd8; cidle = 4'(thr);
        pulse_tick(2);
        rd_e = 1; wr_e = 1;
        if (thr > 0) begin
            repeat (thr) @(negedge clk);
            chk($sformatf("R4 no req before window thr=%0d", thr), int'(req), 0);
        end
        @(negedge clk);
        chk($sformatf("R4 req at window thr=%0d", thr), int'(req), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 req after reset", int'(req), 0);
        chk("R1 urgent after reset", int'(urg), 0);
        chk("R1 pend after reset", int'(pend), 0);

        // R2 / R9 table: saturation and self-refresh gating
        foreach (TAB[k]) begin
            do_reset();
            sen = 1; rd_e = 1; wr_e = 1; cidle = 0;
            cmax = TAB[k][11:8];
            pulse_tick(int'(TAB[k][7:4]));
            repeat (2) @(negedge clk);
            chk($sformatf("R2 backlog entry %0d", k), int'(pend), int'(TAB[k][3:0]));
            chk($sformatf("R9 no req before sref entry %0d", k), int'(req), 0);
            sact = 1;
            for (int j = 0; j < int'(TAB[k][3:0]); j++) begin
                do_ack();
                chk($sformatf("R9 sref issue entry %0d", k), int'(got), 1);
                chk($sformatf("R9 sref not urgent entry %0d", k), int'(last_urg), 0);
            end
            chk($sformatf("R9 drained entry %0d", k), int'(pend), 0);
        end

        // R4 idle window boundaries
        window(0);
        window(5);
        window(15);

        // R4 restart of window on a busy cycle
        do_reset();
        cmax = 8; cidle = 5; pulse_tick(1);
        rd_e = 1; wr_e = 1;
        repeat (4) @(negedge clk);
        rd_e = 0; @(negedge clk); rd_e = 1;
        repeat (5) @(negedge clk);
        chk("R4 window restarted", int'(req), 0);
        @(negedge clk);
        chk("R4 req after restarted window", int'(req), 1);

        // R5 batch, R7 hold, R8 busy gap
        do_reset();
        cmax = 8; cidle = 2; pulse_tick(3);
        rd_e = 1; wr_e = 1;
        do_ack();
        chk("R5 first batch refresh", int'(got), 1);
        chk("R7 req low after accept", int'(req), 0);
        for (int i = 1; i <= BUSY; i++) begin
            @(negedge clk);
            if (i == BUSY) chk("R8 req low during busy", int'(req), 0);
        end
        @(negedge clk);
        chk("R8 req back after busy", int'(req), 1);
        rd_e = 0;
        repeat (3) @(negedge clk);
        chk("R7 req held without ack", int'(req), 1);
        do_ack();
        chk("R5 pend after second", int'(pend), 1);
        repeat (20) @(negedge clk);
        chk("R5 batch stops when busy", int'(req), 0);
        chk("R5 backlog kept", int'(pend), 1);

        // R6 urgent escalation, exactly one
        do_reset();
        cmax = 3; cidle = 4; pulse_tick(3);
        do_ack();
        chk("R6 urgent refresh issued", int'(got), 1);
        chk("R6 urgent flag", int'(last_urg), 1);
        repeat (20) @(negedge clk);
        chk("R6 only one urgent", int'(req), 0);
        chk("R6 pend after urgent", int'(pend), 2);
        rd_e = 1; wr_e = 1;
        do_ack();
        chk("R6 normal waiting resumes", int'(last_urg), 0);
        do_ack();
        chk("R6 backlog drained", int'(pend), 0);

        // R3 tick in accept cycle
        do_reset();
        cmax = 8; cidle = 0; rd_e = 1; wr_e = 1;
        pulse_tick(1);
        for (int i = 0; i < 50 && !req; i++) @(negedge clk);
        ack = 1; tick = 1; @(negedge clk); ack = 0; tick = 0;
        chk("R3 tick plus accept unchanged", int'(pend), 1);
        do_ack();
        chk("R3 accept decrements", int'(pend), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule